// File: doc/BRIEF.md
# Double-Buffered Timer Compare Channel

This block is one comparator channel that sits beside a 16-bit timer counter. Software writes a new compare value into a pending register. The comparator uses a separate active register. A 3-bit load-mode input selects the counter event at which the pending value is copied into the active register. Because of this, a compare threshold can be changed safely at a point in the count cycle that software chooses.

On every timer clock, the channel compares the counter with the active value. It raises a match pulse when the two are equal. In one load mode the match also asks the counter to restart. The restart value depends on the counter's count mode. A select input places the channel in capture mode. In that mode the comparator is idle and the load modes are ignored. When the channel returns to comparator mode, the pending value becomes active at once.

Top module: `tmr_cmp_chan`

## Requirements
- R1: While `arst_n` is low, and after reset, both the active value and the pending value are zero. Reset release is synchronised to `clk` through two flops.
- R2: A write (`ccr_wr` high at a rising edge) stores `ccr_wdata` only as the pending value. The active value changes only at a load event.
- R3: Load mode 0: the active value takes the pending value at the first rising edge after the edge that captured the write. This holds in every count mode.
- R4: Load mode 1 loads when the counter equals `cnt_max` in up mode, equals 0 in down mode, and at either value in up/down mode. Count-mode codes are 0 for up, 1 for down and 2 for up/down. Code 3 behaves as up.
- R5: Load mode 2 loads whenever the counter equals the active value, in any count mode.
- R6: Load mode 3 loads when the counter is 0 in up mode and when it equals `cnt_max` in down mode. In up/down mode it loads when the counter equals the active value or is 0.
- R7: Load mode 4 loads on a match. In the same cycle it raises `cnt_reload`. `cnt_reload_val` is `cnt_max` in down mode and 0 otherwise.
- R8: Load modes 5, 6 and 7 never load. The active value is held.
- R9: `cmp_match` is high in a comparator-mode cycle exactly when the counter equals the active value as it stood before any load at that cycle's closing edge.
- R10: While `cap_sel` is 1 (capture), no load happens and `cmp_match` and `cnt_reload` stay low. Writes still update the pending value.
- R11: At the first edge where `cap_sel` is 0 after a cycle where it was 1, the active value takes the pending value, whatever the load mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| arst_n | input | 1 | Asynchronous active-low reset |
| cnt_val | input | 16 | Current counter value |
| cnt_max | input | 16 | Counter upper limit |
| cnt_mode | input | 2 | Count mode: 0 up, 1 down, 2 up/down, 3 as up |
| buf_mode | input | 3 | Load-point selector, 0..4 valid, 5..7 never load |
| cap_sel | input | 1 | 1 = capture mode, 0 = comparator mode |
| ccr_wr | input | 1 | Compare-register write strobe |
| ccr_wdata | input | 16 | Compare-register write data |
| cmp_active | output | 16 | Active compare value |
| cmp_match | output | 1 | Counter equals active value |
| cnt_reload | output | 1 | Counter restart request (load mode 4) |
| cnt_reload_val | output | 16 | Value the counter restarts at |

## Verification
The bound assertions watch several properties on every cycle. They check that a restart request only comes with a match in mode 4, and that the restart value in down mode is the limit. They check that capture mode keeps the comparator silent and the active value frozen, and that reserved modes hold the active value. They also check that a mode-change back to comparator mode, a mode-2 match and the mode-0 write delay each make the pending value active. The count-mode-dependent load points of modes 1 and 3, and the interplay between writes and coincident loads, are shown only by the bench's sweeps. Those sweeps run every load mode against up, down, up/down and the aliased count mode, with capture windows inside them.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
  localparam logic [1:0] CM_UP   = 2'd0;
  localparam logic [1:0] CM_DOWN = 2'd1;
  localparam logic [1:0] CM_UPDN = 2'd2;

  localparam logic [2:0] BL_WRITE   = 3'd0;
  localparam logic [2:0] BL_EXTREME = 3'd1;
  localparam logic [2:0] BL_MATCH   = 3'd2;
  localparam logic [2:0] BL_WRAP    = 3'd3;
  localparam logic [2:0] BL_MATCHRS = 3'd4;
endpackage

// File: rtl/tcc_rst_sync.sv
module tcc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  generate
    genvar g;
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge arst_n) begin
          if (!arst_n) sync_q[g] <= 1'b0;
          else         sync_q[g] <= 1'b1;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge arst_n) begin
          if (!arst_n) sync_q[g] <= 1'b0;
          else         sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/tcc_evt_dec.sv
module tcc_evt_dec
  import tcc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] max_i,
  input  logic [W-1:0] act_i,
  input  logic [1:0]   cm_i,
  input  logic [2:0]   bm_i,
  input  logic         dirty_i,
  output logic         match_o,
  output logic         load_evt_o,
  output logic         rst_req_o,
  output logic [W-1:0] rld_val_o
);
  logic at_max, at_zero, is_down, is_updn;

  always_comb begin
    match_o = (cnt_i == act_i);
    at_max  = (cnt_i == max_i);
    at_zero = (cnt_i == '0);
    is_down = (cm_i == CM_DOWN);
    is_updn = (cm_i == CM_UPDN);

    case (bm_i)
      BL_WRITE:   load_evt_o = dirty_i;
      BL_EXTREME: load_evt_o = is_updn ? (at_max | at_zero) :
                               (is_down ? at_zero : at_max);
      BL_MATCH:   load_evt_o = match_o;
      BL_WRAP:    load_evt_o = is_updn ? (match_o | at_zero) :
                               (is_down ? at_max : at_zero);
      BL_MATCHRS: load_evt_o = match_o;
      default:    load_evt_o = 1'b0;
    endcase

    rst_req_o = (bm_i == BL_MATCHRS) && match_o;
    rld_val_o = is_down ? max_i : '0;
  end
endmodule

// File: rtl/tcc_buf_regs.sv
module tcc_buf_regs #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         cap_i,
  input  logic         load_evt_i,
  output logic [W-1:0] act_o,
  output logic [W-1:0] pend_o,
  output logic         dirty_o,
  output logic         cap_q_o
);
  logic [W-1:0] act_q, act_d, pend_q, pend_d;
  logic         dirty_q, dirty_d, cap_q, cap_d;
  logic         do_load;
  logic         act_en, pend_en;

  always_comb begin
    do_load = !cap_i && (cap_q || load_evt_i);
    act_en  = do_load;
    act_d   = pend_q;
    pend_en = wr_i;
    pend_d  = wdata_i;
    if (wr_i)         dirty_d = 1'b1;
    else if (do_load) dirty_d = 1'b0;
    else              dirty_d = dirty_q;
    cap_d = cap_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= '0;
      pend_q  <= '0;
      dirty_q <= 1'b0;
      cap_q   <= 1'b0;
    end else begin
      if (act_en)  act_q  <= act_d;
      if (pend_en) pend_q <= pend_d;
      dirty_q <= dirty_d;
      cap_q   <= cap_d;
    end
  end

  assign act_o   = act_q;
  assign pend_o  = pend_q;
  assign dirty_o = dirty_q;
  assign cap_q_o = cap_q;
endmodule

// File: rtl/tmr_cmp_chan.sv
module tmr_cmp_chan #(
  parameter int CNT_W = 16,
  parameter int RST_STAGES = 2
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic [CNT_W-1:0] cnt_max,
  input  logic [1:0]       cnt_mode,
  input  logic [2:0]       buf_mode,
  input  logic             cap_sel,
  input  logic             ccr_wr,
  input  logic [CNT_W-1:0] ccr_wdata,
  output logic [CNT_W-1:0] cmp_active,
  output logic             cmp_match,
  output logic             cnt_reload,
  output logic [CNT_W-1:0] cnt_reload_val
);
  logic             rst_n_s;
  logic [CNT_W-1:0] act, pend, rld_val;
  logic             dirty, cap_q, eq_raw, load_evt, rst_req;

  tcc_rst_sync #(.STAGES(RST_STAGES)) u_rsync (
    .clk(clk), .arst_n(arst_n), .rst_n_o(rst_n_s)
  );

  tcc_evt_dec #(.W(CNT_W)) u_dec (
    .cnt_i(cnt_val), .max_i(cnt_max), .act_i(act), .cm_i(cnt_mode),
    .bm_i(buf_mode), .dirty_i(dirty), .match_o(eq_raw),
    .load_evt_o(load_evt), .rst_req_o(rst_req), .rld_val_o(rld_val)
  );

  tcc_buf_regs #(.W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n_s), .wr_i(ccr_wr), .wdata_i(ccr_wdata),
    .cap_i(cap_sel), .load_evt_i(load_evt), .act_o(act), .pend_o(pend),
    .dirty_o(dirty), .cap_q_o(cap_q)
  );

  assign cmp_active     = act;
  assign cmp_match      = !cap_sel && eq_raw;
  assign cnt_reload     = !cap_sel && rst_req;
  assign cnt_reload_val = rld_val;
endmodule

// File: rtl/tcc_chk.sv
module tcc_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt_max,
  input logic [1:0]       cnt_mode,
  input logic [2:0]       buf_mode,
  input logic             cap_sel,
  input logic             cap_q,
  input logic             ccr_wr,
  input logic [CNT_W-1:0] ccr_wdata,
  input logic [CNT_W-1:0] pend,
  input logic [CNT_W-1:0] cmp_active,
  input logic             cmp_match,
  input logic             cnt_reload,
  input logic [CNT_W-1:0] cnt_reload_val
);
  always @(posedge clk) begin
    if (rst_n === 1'b0) begin
      p_reset_clear_r1: assert (cmp_active == '0 && pend == '0);
    end
  end

  p_mode0_delay_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ccr_wr && buf_mode == 3'd0 && !cap_sel) ##1
    (!ccr_wr && buf_mode == 3'd0 && !cap_sel)
    |=> cmp_active == $past(ccr_wdata, 2));

  p_match_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_match && buf_mode == 3'd2) |=> cmp_active == $past(pend));

  p_reload_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_reload |-> (cmp_match && buf_mode == 3'd4));

  p_reload_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_reload && cnt_mode == 2'd1) |-> cnt_reload_val == cnt_max);

  p_rsv_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_mode >= 3'd5 && !cap_sel && !cap_q) |=> $stable(cmp_active));

  p_cap_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cap_sel |-> (!cmp_match && !cnt_reload));

  p_cap_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cap_sel |=> $stable(cmp_active));

  p_switch_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_sel && cap_q) |=> cmp_active == $past(pend));
endmodule

bind tmr_cmp_chan tcc_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n_s), .cnt_max(cnt_max), .cnt_mode(cnt_mode),
  .buf_mode(buf_mode), .cap_sel(cap_sel), .cap_q(cap_q), .ccr_wr(ccr_wr),
  .ccr_wdata(ccr_wdata), .pend(pend), .cmp_active(cmp_active),
  .cmp_match(cmp_match), .cnt_reload(cnt_reload),
  .cnt_reload_val(cnt_reload_val)
);

// File: tb/tmr_cmp_chan_tb.sv
module tmr_cmp_chan_tb;
  localparam int MAXV = 9;

  logic        clk = 1'b0;
  logic        arst_n;
  logic [15:0] cnt_val, cnt_max, ccr_wdata;
  logic [1:0]  cnt_mode;
  logic [2:0]  buf_mode;
  logic        cap_sel, ccr_wr;
  logic [15:0] cmp_active, cnt_reload_val;
  logic        cmp_match, cnt_reload;

  int n_tests = 0;
  int n_fail  = 0;

  logic [15:0] m_act, m_pend;
  logic        m_dirty, m_capq;
  string       last_tag;

  always #4 clk = ~clk;

  tmr_cmp_chan u_dut (
    .clk(clk), .arst_n(arst_n), .cnt_val(cnt_val), .cnt_max(cnt_max),
    .cnt_mode(cnt_mode), .buf_mode(buf_mode), .cap_sel(cap_sel),
    .ccr_wr(ccr_wr), .ccr_wdata(ccr_wdata), .cmp_active(cmp_active),
    .cmp_match(cmp_match), .cnt_reload(cnt_reload),
    .cnt_reload_val(cnt_reload_val)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] cnt_seq(input int cm, input int i);
    int p;
    case (cm)
      1: return 16'(MAXV - (i % (MAXV + 1)));
      2: begin
        p = i % (2 * MAXV);
        return 16'((p <= MAXV) ? p : 2 * MAXV - p);
      end
      default: return 16'(i % (MAXV + 1));
    endcase
  endfunction

  function automatic string mode_tag(input int bm);
    case (bm)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      3: return "R6";
      4: return "R7";
      default: return "R8";
    endcase
  endfunction

  // One cycle: drive at negedge, check, advance the model for the coming edge.
  task automatic step(input logic [15:0] c, input logic [1:0] cm, input logic [2:0] bm,
                      input logic cp, input logic w, input logic [15:0] d,
                      input string tag_next);
    logic eq, ev, ld, emat, erld;
    @(negedge clk);
    cnt_val = c; cnt_mode = cm; buf_mode = bm; cap_sel = cp;
    ccr_wr = w; ccr_wdata = d; cnt_max = 16'(MAXV);
    #1;
    check(last_tag, cmp_active, m_act);
    eq   = (c == m_act);
    emat = !cp && eq;
    erld = emat && (bm == 3'd4);
    check(cp ? "R10" : "R9", {15'd0, cmp_match}, {15'd0, emat});
    check(cp ? "R10" : "R7", {15'd0, cnt_reload}, {15'd0, erld});
    if (erld) check("R7", cnt_reload_val, (cm == 2'd1) ? 16'(MAXV) : 16'd0);
    case (bm)
      3'd0: ev = m_dirty;
      3'd1: ev = (cm == 2'd2) ? (c == MAXV || c == 0) : (cm == 2'd1) ? (c == 0) : (c == MAXV);
      3'd2, 3'd4: ev = eq;
      3'd3: ev = (cm == 2'd2) ? (eq || c == 0) : (cm == 2'd1) ? (c == MAXV) : (c == 0);
      default: ev = 1'b0;
    endcase
    ld = !cp && (m_capq || ev);
    if (cp) last_tag = "R10";
    else if (m_capq) last_tag = "R11";
    else last_tag = tag_next;
    if (ld) m_act = m_pend;
    if (w) m_dirty = 1'b1; else if (ld) m_dirty = 1'b0;
    if (w) m_pend = d;
    m_capq = cp;
  endtask

  initial begin
    #1_000_000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    arst_n = 1'b0;
    cnt_val = 16'd3; cnt_max = 16'(MAXV); cnt_mode = 2'd0; buf_mode = 3'd0;
    cap_sel = 1'b1; ccr_wr = 1'b0; ccr_wdata = 16'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", cmp_active, 16'd0);
    check("R1", {15'd0, cnt_reload}, 16'd0);
    arst_n = 1'b1;
    repeat (3) @(posedge clk);
    check("R1", cmp_active, 16'd0);
    m_act = 16'd0; m_pend = 16'd0; m_dirty = 1'b0; m_capq = 1'b1; last_tag = "R1";

    for (int bm = 0; bm < 8; bm++) begin
      for (int cm = 0; cm < 4; cm++) begin
        for (int i = 0; i < 60; i++) begin
          step(cnt_seq(cm, i), 2'(cm), 3'(bm), (i >= 40 && i <= 45),
               (i % 7 == 3), 16'((i * 3 + 1) % (MAXV + 1)), mode_tag(bm));
        end
      end
    end

    // R2: a write in match mode with no match must leave the active value alone.
    step(16'd15, 2'd0, 3'd2, 1'b0, 1'b1, 16'd7, "R2");
    step(16'd15, 2'd0, 3'd2, 1'b0, 1'b0, 16'd0, "R2");
    step(16'd15, 2'd0, 3'd2, 1'b0, 1'b0, 16'd0, "R2");
    step(16'd15, 2'd0, 3'd2, 1'b0, 1'b0, 16'd0, "R2");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule